// File: doc/BRIEF.md
# Banked Single-Precision Register File

This block stores sixty-four 32-bit floating-point registers as plain bit patterns. It performs no arithmetic on them. The same storage can be reached through eight addressing views. Each view has its own index input, read output and write enable, and all views share one 64-bit write data bus.

The views are:
- direct single-register access;
- a current-bank single view, offset by 16 when the bank select bit is high;
- an opposite-bank single view, offset by 16 when the bank select bit is low;
- three register-pair views (direct, current bank and opposite bank), each returning a 64-bit value;
- a 4-register vector base view;
- a 16-register matrix base view.

The bank select bit comes from a status block elsewhere. It is registered inside this block, so a change reaches the addressing one cycle later.

Reads are combinational from the stored state. At most one write is performed per clock edge. If several write enables are raised together, a fixed priority picks the winner and the other writes are dropped. The ports are plain control and data pins with no handshake. Every read view is valid in every cycle, and a write is taken on the edge that samples its enable.

Top module: `fp_bank_regfile`

## Requirements
- R1: After reset every one of the 64 registers reads as zero through every view.
- R2: The direct single view reads register `sgl_idx`. When it writes, register `sgl_idx` takes `wr_data[31:0]`.
- R3: The current-bank single view accesses register (16*FR + `bnk_idx`) mod 64, where FR is the registered bank bit.
- R4: The opposite-bank single view accesses register (16*(1-FR) + `xbk_idx`) mod 64.
- R5: A pair view at base i reads register i in bits [63:32] and register (i+1) mod 64 in bits [31:0]. A pair write stores `wr_data[63:32]` into register i and `wr_data[31:0]` into register (i+1) mod 64.
- R6: The current-bank and opposite-bank pair views add the offset of R3 or R4 to the index first, and then apply the pair mapping of R5 to the result.
- R7: The vector view accesses register 4*(`vec_idx` mod 16). Single writes through it take `wr_data[31:0]`.
- R8: The matrix view accesses register 16*(`mtx_idx` mod 4). Single writes through it take `wr_data[31:0]`.
- R9: `fr_bit` is sampled on each rising clock edge. A new value changes the bank views from the next cycle on, not in the cycle it is applied.
- R10: At most one write is performed per edge. The priority, from highest to lowest, is direct single, current-bank single, opposite-bank single, direct pair, current-bank pair, opposite-bank pair, vector, matrix. Losing writes leave every register unchanged.
- R11: Data written on an edge is visible on every view that maps to that register starting in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_bit | input | 1 | Bank select bit from the status block |
| wr_data | input | 64 | Shared write data; single writes use bits [31:0] |
| sgl_idx | input | 6 | Direct single view index |
| sgl_we | input | 1 | Direct single view write enable |
| sgl_rd | output | 32 | Direct single view read data |
| bnk_idx | input | 6 | Current-bank single view index |
| bnk_we | input | 1 | Current-bank single view write enable |
| bnk_rd | output | 32 | Current-bank single view read data |
| xbk_idx | input | 6 | Opposite-bank single view index |
| xbk_we | input | 1 | Opposite-bank single view write enable |
| xbk_rd | output | 32 | Opposite-bank single view read data |
| pr_idx | input | 6 | Direct pair view base index |
| pr_we | input | 1 | Direct pair view write enable |
| pr_rd | output | 64 | Direct pair view read data |
| bpr_idx | input | 6 | Current-bank pair view index |
| bpr_we | input | 1 | Current-bank pair view write enable |
| bpr_rd | output | 64 | Current-bank pair view read data |
| xpr_idx | input | 6 | Opposite-bank pair view index |
| xpr_we | input | 1 | Opposite-bank pair view write enable |
| xpr_rd | output | 64 | Opposite-bank pair view read data |
| vec_idx | input | 6 | Vector view index (low 4 bits used) |
| vec_we | input | 1 | Vector view write enable |
| vec_rd | output | 32 | Vector view base register read data |
| mtx_idx | input | 6 | Matrix view index (low 2 bits used) |
| mtx_we | input | 1 | Matrix view write enable |
| mtx_rd | output | 32 | Matrix view base register read data |

## Verification
The bench concentrates on wrap-around:
- a pair at base 63 must pull its low half from register 0; a design without the modulo would read past the end of the array or take a stale register;
- a bank offset applied to an index near 63 must fold back to the bottom of the file.

The bench also toggles the bank bit and checks that reads in that same cycle still use the old bank. A design that decoded `fr_bit` combinationally would switch banks one cycle early.

Finally, the bench raises several write enables together and confirms that only the highest-priority view lands. An inverted or missing priority would corrupt a second register.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

  typedef enum logic [2:0] {
    V_SGL  = 3'd0,
    V_BNK  = 3'd1,
    V_XBK  = 3'd2,
    V_PR   = 3'd3,
    V_BPR  = 3'd4,
    V_XPR  = 3'd5,
    V_VEC  = 3'd6,
    V_MTX  = 3'd7
  } view_e;

  localparam int unsigned NVIEW = 8;

  // Pair views read and write two adjacent registers.
  function automatic logic view_is_pair(input int unsigned v);
    return (v == int'(V_PR)) || (v == int'(V_BPR)) || (v == int'(V_XPR));
  endfunction

endpackage

// File: rtl/fprf_index_map.sv
module fprf_index_map
  import fprf_pkg::*;
#(
  parameter int unsigned NREG    = 64,
  parameter int unsigned BANK    = 16,
  parameter int unsigned VEC_LEN = 4,
  parameter int unsigned MTX_LEN = 16,
  parameter view_e       KIND    = V_SGL,
  parameter int unsigned AW      = $clog2(NREG)
) (
  input  logic [AW-1:0] idx,
  input  logic          fr_q,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] BANK_OFS = AW'(BANK);

  generate
    if (KIND == V_SGL || KIND == V_PR) begin : g_direct
      logic fr_unused;
      assign fr_unused = fr_q;
      assign addr = idx;
    end else if (KIND == V_BNK || KIND == V_BPR) begin : g_cur_bank
      // Power-of-two file: truncating the sum gives the modulo wrap.
      assign addr = idx + (fr_q ? BANK_OFS : '0);
    end else if (KIND == V_XBK || KIND == V_XPR) begin : g_opp_bank
      assign addr = idx + (fr_q ? '0 : BANK_OFS);
    end else if (KIND == V_VEC) begin : g_vector
      localparam int unsigned VSH = $clog2(VEC_LEN);
      logic            fr_unused;
      logic [VSH-1:0]  idx_unused;
      assign fr_unused  = fr_q;
      assign idx_unused = idx[AW-1 -: VSH];
      assign addr = {idx[AW-VSH-1:0], {VSH{1'b0}}};
    end else begin : g_matrix
      localparam int unsigned MSH = $clog2(MTX_LEN);
      logic            fr_unused;
      logic [MSH-1:0]  idx_unused;
      assign fr_unused  = fr_q;
      assign idx_unused = idx[AW-1 -: MSH];
      assign addr = {idx[AW-MSH-1:0], {MSH{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/fprf_wr_arb.sv
module fprf_wr_arb #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  // Lowest index has the highest priority.
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int k = 0; k < N; k++) begin
      if (req[k] && !taken) begin
        gnt[k] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R10
  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0); // R10
  AST_REQ_GETS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt)); // R10

endmodule

// File: rtl/fprf_storage.sv
module fprf_storage #(
  parameter int unsigned NREG = 64,
  parameter int unsigned RW   = 32,
  parameter int unsigned NRD  = 11,
  parameter int unsigned AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_pair,
  input  logic [AW-1:0] wr_addr,
  input  logic [RW-1:0] wr_hi,
  input  logic [RW-1:0] wr_lo,
  input  logic [AW-1:0] rd_addr [NRD],
  output logic [RW-1:0] rd_data [NRD]
);

  logic [RW-1:0] mem [NREG];
  logic [AW-1:0] wr_addr_lo;

  assign wr_addr_lo = wr_addr + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) mem[r] <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_addr == AW'(r))
          mem[r] <= wr_hi;
        else if (wr_pair && wr_addr_lo == AW'(r))
          mem[r] <= wr_lo;
      end
    end
  end

  generate
    for (genvar k = 0; k < NRD; k++) begin : g_rd
      assign rd_data[k] = mem[rd_addr[k]];
    end
  endgenerate

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_hi)); // R11
  AST_PAIR_LO_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pair) |=> mem[$past(wr_addr_lo)] == $past(wr_lo)); // R5

endmodule

// File: rtl/fp_bank_regfile.sv
module fp_bank_regfile
  import fprf_pkg::*;
#(
  parameter int unsigned NREG    = 64,
  parameter int unsigned RW      = 32,
  parameter int unsigned BANK    = 16,
  parameter int unsigned VEC_LEN = 4,
  parameter int unsigned MTX_LEN = 16,
  parameter int unsigned AW      = $clog2(NREG),
  parameter int unsigned DW      = 2 * RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fr_bit,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] sgl_idx,
  input  logic          sgl_we,
  output logic [RW-1:0] sgl_rd,
  input  logic [AW-1:0] bnk_idx,
  input  logic          bnk_we,
  output logic [RW-1:0] bnk_rd,
  input  logic [AW-1:0] xbk_idx,
  input  logic          xbk_we,
  output logic [RW-1:0] xbk_rd,
  input  logic [AW-1:0] pr_idx,
  input  logic          pr_we,
  output logic [DW-1:0] pr_rd,
  input  logic [AW-1:0] bpr_idx,
  input  logic          bpr_we,
  output logic [DW-1:0] bpr_rd,
  input  logic [AW-1:0] xpr_idx,
  input  logic          xpr_we,
  output logic [DW-1:0] xpr_rd,
  input  logic [AW-1:0] vec_idx,
  input  logic          vec_we,
  output logic [RW-1:0] vec_rd,
  input  logic [AW-1:0] mtx_idx,
  input  logic          mtx_we,
  output logic [RW-1:0] mtx_rd
);

  localparam int unsigned NPAIR = 3;
  localparam int unsigned NRD   = NVIEW + NPAIR;

  logic                fr_q;
  logic [AW-1:0]       view_idx  [NVIEW];
  logic [AW-1:0]       view_addr [NVIEW];
  logic [NVIEW-1:0]    view_we;
  logic [NVIEW-1:0]    view_gnt;
  logic [AW-1:0]       rd_addr   [NRD];
  logic [RW-1:0]       rd_data   [NRD];
  logic                w_en;
  logic                w_pair;
  logic [AW-1:0]       w_addr;
  logic [RW-1:0]       w_hi;

  // Bank bit is registered: a change steers the views one cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fr_q <= 1'b0;
    else        fr_q <= fr_bit;
  end

  assign view_idx[V_SGL] = sgl_idx;
  assign view_idx[V_BNK] = bnk_idx;
  assign view_idx[V_XBK] = xbk_idx;
  assign view_idx[V_PR]  = pr_idx;
  assign view_idx[V_BPR] = bpr_idx;
  assign view_idx[V_XPR] = xpr_idx;
  assign view_idx[V_VEC] = vec_idx;
  assign view_idx[V_MTX] = mtx_idx;

  assign view_we = {mtx_we, vec_we, xpr_we, bpr_we, pr_we, xbk_we, bnk_we, sgl_we};

  generate
    for (genvar k = 0; k < NVIEW; k++) begin : g_map
      fprf_index_map #(
        .NREG    (NREG),
        .BANK    (BANK),
        .VEC_LEN (VEC_LEN),
        .MTX_LEN (MTX_LEN),
        .KIND    (view_e'(k)),
        .AW      (AW)
      ) i_map (
        .idx  (view_idx[k]),
        .fr_q (fr_q),
        .addr (view_addr[k])
      );
      assign rd_addr[k] = view_addr[k];
    end
    // Second register of each pair view, wrapping past the top of the file.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair_lo
      assign rd_addr[NVIEW+p] = view_addr[int'(V_PR)+p] + AW'(1);
    end
  endgenerate

  fprf_wr_arb #(.N(NVIEW)) i_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (view_we),
    .gnt   (view_gnt)
  );

  always_comb begin
    w_addr = '0;
    w_pair = 1'b0;
    for (int k = 0; k < NVIEW; k++) begin
      if (view_gnt[k]) begin
        w_addr = view_addr[k];
        w_pair = view_is_pair(k);
      end
    end
  end

  assign w_en = |view_gnt;
  assign w_hi = w_pair ? wr_data[DW-1:RW] : wr_data[RW-1:0];

  fprf_storage #(
    .NREG (NREG),
    .RW   (RW),
    .NRD  (NRD),
    .AW   (AW)
  ) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (w_en),
    .wr_pair (w_pair),
    .wr_addr (w_addr),
    .wr_hi   (w_hi),
    .wr_lo   (wr_data[RW-1:0]),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign sgl_rd = rd_data[V_SGL];
  assign bnk_rd = rd_data[V_BNK];
  assign xbk_rd = rd_data[V_XBK];
  assign vec_rd = rd_data[V_VEC];
  assign mtx_rd = rd_data[V_MTX];
  assign pr_rd  = {rd_data[V_PR],  rd_data[NVIEW+0]};
  assign bpr_rd = {rd_data[V_BPR], rd_data[NVIEW+1]};
  assign xpr_rd = {rd_data[V_XPR], rd_data[NVIEW+2]};

  AST_BANKS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (bnk_idx == xbk_idx) |->
      ((fr_q ? (view_addr[V_BNK] - view_addr[V_XBK])
             : (view_addr[V_XBK] - view_addr[V_BNK])) == AW'(BANK))); // R4
  AST_PAIR_HI_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_idx == sgl_idx) |-> (pr_rd[DW-1:RW] == sgl_rd)); // R5
  AST_BANK_PAIR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (bpr_idx == bnk_idx) |-> (bpr_rd[DW-1:RW] == bnk_rd)); // R6
  AST_VEC_MTX_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_idx[3:0] == {mtx_idx[1:0], 2'b00}) |-> (vec_rd == mtx_rd)); // R7

endmodule

// File: tb/test_fp_bank_regfile.sv
`timescale 1ns/1ps
module test_fp_bank_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fr_bit = 1'b0;
  logic [63:0] wr_data = '0;
  logic [5:0]  idx [8];
  logic        we  [8];
  logic [63:0] rd_all [8];

  logic [31:0] sgl_rd, bnk_rd, xbk_rd, vec_rd, mtx_rd;
  logic [63:0] pr_rd, bpr_rd, xpr_rd;

  // Shadow stimulus, copied onto the pins at the falling edge.
  logic [5:0]  n_idx [8];
  logic        n_we  [8];
  logic [63:0] n_data;
  logic        n_fr;

  logic [31:0] m [64];
  int          fr_m;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  fp_bank_regfile i_fp_bank_regfile (
    .clk(clk), .rst_n(rst_n), .fr_bit(fr_bit), .wr_data(wr_data),
    .sgl_idx(idx[0]), .sgl_we(we[0]), .sgl_rd(sgl_rd),
    .bnk_idx(idx[1]), .bnk_we(we[1]), .bnk_rd(bnk_rd),
    .xbk_idx(idx[2]), .xbk_we(we[2]), .xbk_rd(xbk_rd),
    .pr_idx(idx[3]),  .pr_we(we[3]),  .pr_rd(pr_rd),
    .bpr_idx(idx[4]), .bpr_we(we[4]), .bpr_rd(bpr_rd),
    .xpr_idx(idx[5]), .xpr_we(we[5]), .xpr_rd(xpr_rd),
    .vec_idx(idx[6]), .vec_we(we[6]), .vec_rd(vec_rd),
    .mtx_idx(idx[7]), .mtx_we(we[7]), .mtx_rd(mtx_rd)
  );

  assign rd_all[0] = {32'd0, sgl_rd};
  assign rd_all[1] = {32'd0, bnk_rd};
  assign rd_all[2] = {32'd0, xbk_rd};
  assign rd_all[3] = pr_rd;
  assign rd_all[4] = bpr_rd;
  assign rd_all[5] = xpr_rd;
  assign rd_all[6] = {32'd0, vec_rd};
  assign rd_all[7] = {32'd0, mtx_rd};

  string vtag [8] = '{"R2 sgl", "R3 bnk", "R4 xbk", "R5 pr",
                      "R6 bpr", "R6 xpr", "R7 vec", "R8 mtx"};

  function automatic int map_addr(int v, int i, int fr);
    case (v)
      0, 3:    return i;
      1, 4:    return (i + 16 * fr) % 64;
      2, 5:    return (i + 16 * (1 - fr)) % 64;
      6:       return 4 * (i % 16);
      default: return 16 * (i % 4);
    endcase
  endfunction

  function automatic bit pair_view(int v);
    return (v >= 3 && v <= 5);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_stim();
    for (int v = 0; v < 8; v++) begin
      n_idx[v] = '0;
      n_we[v]  = 1'b0;
    end
    n_data = '0;
  endtask

  // One cycle: drive, compare all views, then advance the model at the edge.
  task automatic step(string ctx);
    @(negedge clk);
    for (int v = 0; v < 8; v++) begin
      idx[v] = n_idx[v];
      we[v]  = n_we[v];
    end
    wr_data = n_data;
    fr_bit  = n_fr;
    #1;
    for (int v = 0; v < 8; v++) begin
      int a;
      logic [63:0] e;
      a = map_addr(v, int'(idx[v]), fr_m);
      e = pair_view(v) ? {m[a], m[(a + 1) % 64]} : {32'd0, m[a]};
      chk({ctx, "/", vtag[v]}, rd_all[v], e);
    end
    @(posedge clk);
    if (rst_n) begin
      for (int v = 0; v < 8; v++) begin
        if (we[v]) begin
          int a;
          a = map_addr(v, int'(idx[v]), fr_m);
          if (pair_view(v)) begin
            m[a] = wr_data[63:32];
            m[(a + 1) % 64] = wr_data[31:0];
          end else begin
            m[a] = wr_data[31:0];
          end
          break;
        end
      end
      fr_m = int'(fr_bit);
    end
  endtask

  initial begin
    for (int r = 0; r < 64; r++) m[r] = '0;
    fr_m = 0;
    for (int v = 0; v < 8; v++) begin
      idx[v] = '0;
      we[v]  = 1'b0;
    end
    n_fr = 1'b0;
    clear_stim();
    repeat (3) step("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: sweep the whole file through the direct view
    for (int r = 0; r < 64; r++) begin
      clear_stim();
      n_idx[0] = 6'(r);
      step("R1 sweep");
    end

    // R2 / R11: direct write then readback
    clear_stim(); n_idx[0] = 6'd5; n_we[0] = 1'b1; n_data = 64'h1111_2222_A5A5_0005;
    step("R2 write");
    clear_stim(); n_idx[0] = 6'd5; step("R11 readback");
    chk("R11 direct", {32'd0, sgl_rd}, 64'h0000_0000_A5A5_0005);

    // R9: raise FR; the cycle it changes still uses bank 0
    clear_stim(); n_fr = 1'b1; n_idx[1] = 6'd5; step("R9 same cycle");
    clear_stim(); n_idx[1] = 6'd5; step("R9 next cycle");

    // R3: current bank with FR=1, index 60 wraps to register 12
    clear_stim(); n_idx[1] = 6'd60; n_we[1] = 1'b1; n_data = 64'h0BAD_0BAD_C0DE_000C;
    step("R3 wrap write");
    clear_stim(); n_idx[0] = 6'd12; step("R3 wrap read");
    chk("R3 reg12", {32'd0, sgl_rd}, 64'h0000_0000_C0DE_000C);

    // R4: opposite bank with FR=1 hits register 3
    clear_stim(); n_idx[2] = 6'd3; n_we[2] = 1'b1; n_data = 64'h0000_0000_0000_0333;
    step("R4 write");
    clear_stim(); n_idx[0] = 6'd3; step("R4 read");
    chk("R4 reg3", {32'd0, sgl_rd}, 64'h333);

    // R5: pair at 63 wraps its low half to register 0
    clear_stim(); n_idx[3] = 6'd63; n_we[3] = 1'b1; n_data = 64'hDEAD_BEEF_0123_4567;
    step("R5 wrap write");
    clear_stim(); n_idx[3] = 6'd63; n_idx[0] = 6'd0; step("R5 wrap read");
    chk("R5 low half reg0", {32'd0, sgl_rd}, 64'h0123_4567);

    // R6: current-bank pair, FR=1, index 15 covers registers 31 and 32
    clear_stim(); n_idx[4] = 6'd15; n_we[4] = 1'b1; n_data = 64'hAAAA_0031_BBBB_0032;
    step("R6 write");
    clear_stim(); n_idx[0] = 6'd32; n_idx[5] = 6'd31; step("R6 read");
    chk("R6 reg32", {32'd0, sgl_rd}, 64'hBBBB_0032);

    // R7 / R8: masked vector and matrix bases
    clear_stim(); n_idx[6] = 6'd21; n_we[6] = 1'b1; n_data = 64'h0000_0000_7777_0020;
    step("R7 write");
    clear_stim(); n_idx[0] = 6'd20; step("R7 read");
    chk("R7 reg20", {32'd0, sgl_rd}, 64'h7777_0020);
    clear_stim(); n_idx[7] = 6'd6; n_we[7] = 1'b1; n_data = 64'h0000_0000_8888_0030;
    step("R8 write");
    clear_stim(); n_idx[0] = 6'd32; step("R8 read");
    chk("R8 reg32", {32'd0, sgl_rd}, 64'h8888_0030);

    // R10: all enables together, only the direct view lands
    clear_stim();
    for (int v = 0; v < 8; v++) begin
      n_we[v] = 1'b1;
      n_idx[v] = 6'(40 + v);
    end
    n_data = 64'h9999_9999_5555_5555;
    step("R10 all enables");
    clear_stim(); n_idx[0] = 6'd40; n_idx[1] = 6'd41; n_idx[3] = 6'd43; step("R10 after");
    chk("R10 winner", {32'd0, sgl_rd}, 64'h5555_5555);
    clear_stim(); n_idx[1] = 6'd2; n_we[1] = 1'b1; n_idx[3] = 6'd50; n_we[3] = 1'b1;
    n_data = 64'h4444_4444_6666_6666;
    step("R10 bank over pair");
    clear_stim(); n_idx[3] = 6'd50; step("R10 pair dropped");
    chk("R10 pair untouched", pr_rd, 64'd0);

    // Random traffic compared every cycle
    for (int c = 0; c < 3000; c++) begin
      for (int v = 0; v < 8; v++) begin
        n_idx[v] = 6'($urandom_range(0, 63));
        n_we[v]  = ($urandom_range(0, 11) == 0);
      end
      n_data = {$urandom(), $urandom()};
      if ($urandom_range(0, 7) == 0) n_fr = ~n_fr;
      step("rand");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule